// File: doc/BRIEF.md
# Serial Transmitter with Prioritized Interrupt Vector

This block sends bytes on an asynchronous serial line and tells software, through two flags and a single interrupt line, when it can hand over the next byte and when the line has gone quiet. Software writes a byte into a one-entry holding buffer. On the next baud tick at which the line is free, the byte moves into a shift register and is sent as a frame. The move sets the ready flag, so software can write the next byte while the current one is still being shifted out. A byte that is already waiting when a frame ends starts the next frame on the same tick. The completion flag is raised only when a frame ends with nothing waiting. During a burst it is therefore raised once, at the end of the final byte, and not after every byte.

A vector register reports the highest-priority enabled pending flag as a small even code. Reading it with the read strobe clears the flag it reported. The block takes the bit-rate tick as an input. The frame has one start bit, eight data bits and one or two stop bits.

Register map (the address decides the behaviour):
- address 0: transmit buffer. A write loads a byte; a read returns the last byte written.
- address 1: flags. Bit 0 is ready, bit 1 is complete.
- address 2: control. Bit 0 enables ready, bit 1 enables complete, bit 2 selects two stop bits.
- address 3: vector, read only.

Top module: `uart_tx_vec`

## Requirements
- R1: After reset the ready flag is 1, the complete flag is 0, the control register is 0, the vector reads 0, `irq` is low and `txd` is high.
- R2: When a byte waits in the buffer and the line is free, the frame starts on a baud tick. The frame is a low start bit, then eight data bits sent LSB first, then one high stop bit (control bit 2 = 0) or two (control bit 2 = 1). Each bit lasts one tick interval, and the line is high while idle.
- R3: The ready flag (flags bit 0) is set on the clock edge at which the buffered byte enters the shift register, which is the edge at which the start bit begins. A write to the buffer (address 0) clears it.
- R4: The complete flag (flags bit 1) is set on the tick that ends the last stop bit, and only if no byte is waiting. A byte that is waiting at that tick, including one written during the final stop bit, starts its frame on that same tick with no idle bit between the frames, and the complete flag stays clear.
- R5: The vector (address 3) reads 0 when no enabled flag is pending, 2 when ready is pending and 4 when only complete is pending. Ready takes precedence, and a flag counts only while its enable (control bit 0 for ready, bit 1 for complete) is set.
- R6: A read of address 3 with `rd_en` high returns the current code and clears only the flag that code names. A read that returns 0 clears nothing.
- R7: `irq` is high exactly when some flag is set together with its enable. A flag whose enable is clear stays set and readable without raising `irq`.
- R8: A write to address 1 loads ready from data bit 0 and complete from data bit 1. A hardware set in the same cycle as a software clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; a strobed read of address 3 clears the reported flag |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request: some enabled flag is pending |
| txd | output | 1 | Serial transmit line |

## Verification
The hardest situations to reach from the ports depend on exact timing against the baud tick. One is a byte that lands in the buffer during the final stop bit. The other is a flag write that falls in the same cycle as a hardware set. The bench drives the tick itself, so it knows in which cycle a tick will be seen. It watches its own line decoder finish sampling the stop bit and writes the next byte inside the remaining stop interval. For the collision case, it places the flag-clear write in the cycle whose edge carries the tick that loads a waiting byte. The bench samples the complete flag both at the final stop bit and one tick later, so a flag raised one bit early or one bit late is caught.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  typedef enum logic [1:0] {
    REG_BUF  = 2'd0,
    REG_FLAG = 2'd1,
    REG_CTRL = 2'd2,
    REG_VEC  = 2'd3
  } reg_sel_e;

  localparam int NSRC = 2;  // index 0 = ready (highest priority), 1 = complete
  localparam int SRC_RDY  = 0;
  localparam int SRC_DONE = 1;
endpackage

// File: rtl/uart_tx_rstsync.sv
`timescale 1ns/1ps
module uart_tx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_frame.sv
`timescale 1ns/1ps
module uart_tx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              two_stop,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  output logic              load,
  output logic              done_pulse,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;          // start + data + up to two stops
  localparam int CNT_W   = $clog2(FRAME_W);

  logic               busy_q, busy_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               last_bit;

  always_comb begin
    last_bit   = busy_q && (cnt_q == '0);
    load       = baud_tick && buf_full && (!busy_q || last_bit);
    done_pulse = baud_tick && last_bit && !buf_full;
    busy_n     = busy_q;
    sh_n       = sh_q;
    cnt_n      = cnt_q;
    if (load) begin
      busy_n = 1'b1;
      sh_n   = {2'b11, buf_data, 1'b0};
      cnt_n  = two_stop ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
    end else if (baud_tick && busy_q) begin
      if (last_bit) begin
        busy_n = 1'b0;
      end else begin
        sh_n  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_irqctl.sv
`timescale 1ns/1ps
module uart_tx_irqctl
  import uart_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_rdy,
  input  logic            set_done,
  input  logic            buf_wr,
  input  logic            flag_wr,
  input  logic [NSRC-1:0] flag_wdata,
  input  logic            ctrl_wr,
  input  logic [NSRC:0]   ctrl_wdata,
  input  logic            vec_rd,
  output logic            rdy,
  output logic            done,
  output logic [NSRC-1:0] ien,
  output logic            two_stop,
  output logic [W-1:0]    vec_code,
  output logic            irq
);
  logic            rdy_q, rdy_n, done_q, done_n, stop_q, stop_n;
  logic [NSRC-1:0] ien_q, ien_n, pend, sel;

  always_comb begin
    pend     = {done_q, rdy_q} & ien_q;
    vec_code = '0;
    sel      = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vec_code = W'(2 * (i + 1));
        sel      = '0;
        sel[i]   = 1'b1;
      end
    end
  end

  always_comb begin
    rdy_n  = rdy_q;
    done_n = done_q;
    ien_n  = ien_q;
    stop_n = stop_q;
    if (buf_wr)                    rdy_n = 1'b0;
    else if (set_rdy)              rdy_n = 1'b1;
    else if (vec_rd && sel[SRC_RDY]) rdy_n = 1'b0;
    else if (flag_wr)              rdy_n = flag_wdata[SRC_RDY];
    if (set_done)                  done_n = 1'b1;
    else if (vec_rd && sel[SRC_DONE]) done_n = 1'b0;
    else if (flag_wr)              done_n = flag_wdata[SRC_DONE];
    if (ctrl_wr) begin
      ien_n  = ctrl_wdata[NSRC-1:0];
      stop_n = ctrl_wdata[NSRC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      done_q <= 1'b0;
      ien_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_n;
      done_q <= done_n;
      ien_q  <= ien_n;
      stop_q <= stop_n;
    end
  end

  assign rdy      = rdy_q;
  assign done     = done_q;
  assign ien      = ien_q;
  assign two_stop = stop_q;
  assign irq      = |pend;
endmodule

// File: rtl/uart_tx_vec.sv
`timescale 1ns/1ps
module uart_tx_vec
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              txd
);
  logic              rst_q_n;
  logic              buf_wr, flag_wr, ctrl_wr, vec_rd;
  logic [DATA_W-1:0] buf_q, buf_n;
  logic              full_q, full_n;
  logic              fr_load, fr_done, fr_busy;
  logic              rdy, done, two_stop;
  logic [NSRC-1:0]   ien;
  logic [DATA_W-1:0] vec_code;

  uart_tx_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    buf_wr  = wr_en && (reg_sel_e'(wr_addr) == REG_BUF);
    flag_wr = wr_en && (reg_sel_e'(wr_addr) == REG_FLAG);
    ctrl_wr = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
    vec_rd  = rd_en && (reg_sel_e'(rd_addr) == REG_VEC);
    buf_n   = buf_wr ? wr_data : buf_q;
    full_n  = buf_wr ? 1'b1 : (fr_load ? 1'b0 : full_q);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      full_q <= full_n;
    end
  end

  uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_q_n), .baud_tick(baud_tick), .two_stop(two_stop),
    .buf_full(full_q), .buf_data(buf_q), .load(fr_load), .done_pulse(fr_done),
    .busy(fr_busy), .txd(txd)
  );

  uart_tx_irqctl #(.W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_q_n), .set_rdy(fr_load), .set_done(fr_done),
    .buf_wr(buf_wr), .flag_wr(flag_wr), .flag_wdata(wr_data[NSRC-1:0]),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(wr_data[NSRC:0]), .vec_rd(vec_rd),
    .rdy(rdy), .done(done), .ien(ien), .two_stop(two_stop),
    .vec_code(vec_code), .irq(irq)
  );

  always_comb begin
    case (reg_sel_e'(rd_addr))
      REG_BUF:  rd_data = buf_q;
      REG_FLAG: rd_data = DATA_W'({done, rdy});
      REG_CTRL: rd_data = DATA_W'({two_stop, ien});
      default:  rd_data = vec_code;
    endcase
  end
endmodule

// File: rtl/uart_tx_vec_chk.sv
`timescale 1ns/1ps
module uart_tx_vec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         txd,
  input logic         busy,
  input logic         buf_full,
  input logic         load,
  input logic         buf_wr,
  input logic         flag_wr,
  input logic         vec_rd,
  input logic         rdy,
  input logic         done,
  input logic [1:0]   ien,
  input logic         irq,
  input logic [W-1:0] vec
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  p_rdy_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !buf_wr) |=> rdy);
  p_bufwr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> !rdy);
  p_done_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(flag_wr)) |-> !$past(buf_full));
  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ien[0]) |-> (vec == W'(2)));
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec == W'(2) && !load) |=> !rdy);
  p_irq_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec != '0));
endmodule

bind uart_tx_vec uart_tx_vec_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .txd(txd), .busy(fr_busy), .buf_full(full_q),
  .load(fr_load), .buf_wr(buf_wr), .flag_wr(flag_wr), .vec_rd(vec_rd),
  .rdy(rdy), .done(done), .ien(ien), .irq(irq), .vec(vec_code)
);

// File: tb/sim_uart_tx_vec.sv
`timescale 1ns/1ps
module sim_uart_tx_vec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd1;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq, txd;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  uart_tx_vec u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .txd(txd)
  );

  always #2 clk = ~clk;

  // tick generator and line decoder (sample just after each tick edge)
  int tcnt = 0;
  int dec_state = 0, bitn = 0, stopn = 0, idle_cnt = 0, exp_stops = 1;
  int rx_count = 0, rec_count = 0, stop_err = 0;
  bit pend_rec = 0;
  logic [7:0] shreg;
  logic [7:0] rx_byte [32];
  int  gap [32];
  logic done_pre [32], done_post [32];

  always @(negedge clk) begin
    if (baud_tick) begin
      if (pend_rec) begin
        done_post[rec_count] = rd_data[1];
        rec_count++;
        pend_rec = 0;
      end
      case (dec_state)
        0: if (!txd) begin
             gap[rx_count] = idle_cnt; idle_cnt = 0; dec_state = 1; bitn = 0;
           end else idle_cnt++;
        1: begin
             shreg[bitn] = txd; bitn++;
             if (bitn == 8) begin dec_state = 2; stopn = 0; end
           end
        default: begin
             if (!txd) stop_err++;
             stopn++;
             if (stopn == exp_stops) begin
               rx_byte[rx_count] = shreg; done_pre[rx_count] = rd_data[1];
               rx_count++; pend_rec = 1; idle_cnt = 0; dec_state = 0;
             end
           end
      endcase
    end
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 0);
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    sync(); wr_en = 1'b1; wr_addr = a; wr_data = d;
    sync(); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #0.1; d = rd_data; rd_addr = 2'd1;
  endtask

  task automatic rd_vec(output logic [7:0] d);
    sync(); rd_en = 1'b1; rd_addr = 2'd3; #0.1; d = rd_data;
    sync(); rd_en = 1'b0; rd_addr = 2'd1;
  endtask

  task automatic wait_rec(input int n);
    while (rec_count < n) sync();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    sync();
    peek(2'd1, d); check("R1 flags", d, 1);
    peek(2'd2, d); check("R1 ctrl", d, 0);
    peek(2'd3, d); check("R1 vector", d, 0);
    check("R1 irq", irq, 0);
    check("R1 txd", txd, 1);
  endtask

  task automatic t_single(input logic [7:0] b, input int stops);
    logic [7:0] d;
    int n = rx_count;
    wr(2'd2, (stops == 2) ? 8'h04 : 8'h00);
    exp_stops = stops;
    wr(2'd1, 8'h00);
    wr(2'd0, b);
    peek(2'd1, d); check("R3 ready cleared by buffer write", d[0], 0);
    while (txd) sync();
    peek(2'd1, d); check("R3 ready set at start bit", d[0], 1);
    wait_rec(n + 1);
    check("R2 byte value", rx_byte[n], b);
    check("R2 stop bits high", stop_err, 0);
    check("R4 complete clear during last stop", done_pre[n], 0);
    check("R4 complete set after last stop", done_post[n], 1);
    check("R2 idle high", txd, 1);
  endtask

  task automatic t_burst();
    logic [7:0] d;
    int n = rx_count;
    wr(2'd2, 8'h04); exp_stops = 2;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h3C);
    while (!rd_data[0]) sync();
    wr(2'd0, 8'hA5);
    while (!rd_data[0]) sync();
    wr(2'd0, 8'h81);
    wait_rec(n + 3);
    check("R2 burst byte 0", rx_byte[n], 8'h3C);
    check("R2 burst byte 1", rx_byte[n+1], 8'hA5);
    check("R2 burst byte 2", rx_byte[n+2], 8'h81);
    check("R4 no idle before frame 1", gap[n+1], 0);
    check("R4 no idle before frame 2", gap[n+2], 0);
    check("R4 no complete after frame 0", done_post[n], 0);
    check("R4 no complete after frame 1", done_post[n+1], 0);
    check("R4 complete after last frame", done_post[n+2], 1);
    check("R2 two stop bits high", stop_err, 0);
  endtask

  task automatic t_late_write();
    int n = rx_count;
    wr(2'd2, 8'h00); exp_stops = 1;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h5A);
    while (rx_count < n + 1) sync();   // now inside the only stop bit
    wr(2'd0, 8'hC3);
    wait_rec(n + 2);
    check("R4 late byte value", rx_byte[n+1], 8'hC3);
    check("R4 late byte back-to-back", gap[n+1], 0);
    check("R4 no complete for earlier byte", done_post[n], 0);
    check("R4 complete after late byte", done_post[n+1], 1);
  endtask

  task automatic t_vector();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h03);
    peek(2'd3, d); check("R5 ready code", d, 2);
    check("R7 irq with ready", irq, 1);
    wr(2'd1, 8'h03);
    peek(2'd3, d); check("R5 ready beats complete", d, 2);
    rd_vec(d); check("R6 read returns ready", d, 2);
    peek(2'd1, d); check("R6 only ready cleared", d, 2);
    peek(2'd3, d); check("R5 complete code", d, 4);
    rd_vec(d); check("R6 read returns complete", d, 4);
    peek(2'd1, d); check("R6 complete cleared", d, 0);
    check("R7 irq low when none", irq, 0);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h00);
    check("R7 disabled flags give no irq", irq, 0);
    rd_vec(d); check("R5 disabled gives code 0", d, 0);
    peek(2'd1, d); check("R6 code-0 read clears nothing", d, 3);
    wr(2'd2, 8'h02);
    peek(2'd3, d); check("R5 only complete enabled", d, 4);
    check("R7 irq with complete enabled", irq, 1);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_hw_wins();
    logic [7:0] d;
    int n = rx_count;
    exp_stops = 1;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h96);
    sync();
    while (!baud_tick) sync();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;  // same edge as load
    sync(); wr_en = 1'b0;
    peek(2'd1, d); check("R8 hardware set beats clear", d[0], 1);
    wr(2'd1, 8'h02);
    peek(2'd1, d); check("R8 software writes flags", d, 2);
    wait_rec(n + 1);
    check("R2 byte after collision", rx_byte[n], 8'h96);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_single(8'hB2, 1);
    t_single(8'h4E, 2);
    t_burst();
    t_late_write();
    t_vector();
    t_hw_wins();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule